// File: doc/BRIEF.md
# Configuration Clock Direction and Tail Controller

This block owns the configuration clock pin of a programmable device. A configuration start is signalled by a falling edge on an active-low program request input. At that moment the block samples a mode code and a frequency code. If the mode code is one of the master codes, it drives a divided copy of the internal oscillator onto the pin and raises the pin's output enable. For any other code it leaves the pin released, so that an external master can clock the device.

While driving, the block waits until both the DONE indication and the wake-up-complete indication are high together. It then gives a fixed number of further clock pulses, which lets devices later in a configuration chain finish their own wake-up. After the last pulse it releases the pin and stays idle until the next program request edge. A new request restarts the block from any state.

Top module: `cfg_clk_ctrl`

## Requirements
- R1: While reset is low, and after it is released, `cclk_oe` and `cclk_o` are 0 until a start is detected.
- R2: A falling edge of `prog_req_n` passes through SYNC_STAGES (default 2) synchronizer flops and then one state register. When the mode code sampled then is a master code (bit m of MASTER_MASK is set; by default codes 6 and 7), `cclk_oe` is 1 exactly SYNC_STAGES+1 oscillator cycles after the edge is registered, and it is still 0 one cycle earlier.
- R3: When the sampled mode code is not a master code, `cclk_oe` and `cclk_o` stay 0.
- R4: With frequency code k sampled at start, `cclk_o` equals bit k of the number of oscillator cycles since the first driven cycle. The period is therefore 2^(k+1) cycles, and each period starts with 2^k low cycles.
- R5: Once `done_i` and `wake_done_i` are high in the same cycle while the clock is driven, exactly TAIL_CLKS (default 120) further rising edges appear on `cclk_o`. `cclk_oe` and `cclk_o` fall together at the end of the last high phase, and the pin then stays released.
- R6: `done_i` high without `wake_done_i`, or `wake_done_i` high without `done_i`, does not start the tail count. The clock keeps running unchanged.
- R7: Changes to `freq_sel` after the start has been sampled have no effect on `cclk_o`.
- R8: Once the tail count has begun, dropping `done_i` or `wake_done_i` does not change the number of tail pulses.
- R9: A new falling edge of `prog_req_n` while driving restarts the block. The mode and frequency codes are sampled again, and a master restart begins again with a low phase.
- R10: A rising edge of `prog_req_n` has no effect on the running clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_req_n | input | 1 | Asynchronous program request; its falling edge starts configuration |
| mode_sel | input | MODE_W | Mode code, sampled at start |
| freq_sel | input | FSEL_W | Divide code k (divide by 2^(k+1)), sampled at start |
| done_i | input | 1 | DONE indication |
| wake_done_i | input | 1 | Wake-up sequence complete |
| cclk_o | output | 1 | Clock value driven to the pin |
| cclk_oe | output | 1 | Pin output enable; 0 means the pin is an input |

## Verification
The clock waveform is checked cycle by cycle for every divide code, both from idle and after restarts. Some of these runs hold the inputs steady. Others toggle the frequency code and raise DONE and wake-up one at a time, which separates a latched frequency from a live one and shows whether the tail needs both indications. The tail is counted in rising edges after the registering edge, with DONE dropped partway through, so an off-by-one in the count or an early release shows up. Restarts into a slave code, and random mode and frequency picks, show whether the output direction follows the sampled mode.

// File: rtl/cfg_clk_pkg.sv
package cfg_clk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } cclk_state_e;
endpackage

// File: rtl/cfg_prog_sync.sv
module cfg_prog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  output logic fall
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], req_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall = last_q & ~sync_q[STAGES-1];

  // R2
  fall_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/cfg_clk_div.sv
module cfg_clk_div #(
  parameter int FSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic [FSEL_W-1:0] fsel,
  output logic              cclk_bit,
  output logic              rise_tick,
  output logic              fall_tick
);
  localparam int DIV_W = 2 ** FSEL_W;

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] mask, low;

  always_comb begin
    if (clr || !run) cnt_d = '0;
    else             cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    mask      = (DIV_W'(2) << fsel) - DIV_W'(1);
    low       = cnt_q & mask;
    rise_tick = run && (low == (mask >> 1));
    fall_tick = run && (low == mask);
    cclk_bit  = cnt_q[fsel];
  end

  // R4
  rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && rise_tick) |=> cclk_bit);
  // R4
  fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && fall_tick) |=> !cclk_bit);
endmodule

// File: rtl/cfg_tail_cnt.sv
module cfg_tail_cnt #(
  parameter int TAIL_CLKS = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic reached
);
  localparam int CNT_W = $clog2(TAIL_CLKS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr)                         cnt_d = '0;
    else if (inc && !reached)        cnt_d = cnt_q + CNT_W'(1);
    else                             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign reached = (cnt_q == CNT_W'(TAIL_CLKS));

  // R5
  tail_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(TAIL_CLKS));
endmodule

// File: rtl/cfg_clk_ctrl.sv
module cfg_clk_ctrl
  import cfg_clk_pkg::*;
#(
  parameter int                MODE_W      = 3,
  parameter int                FSEL_W      = 2,
  parameter int                SYNC_STAGES = 2,
  parameter int                TAIL_CLKS   = 120,
  parameter logic [(2**MODE_W)-1:0] MASTER_MASK = 8'hC0
) (
  input  logic              clk_osc,
  input  logic              rst_n,
  input  logic              prog_req_n,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic [FSEL_W-1:0] freq_sel,
  input  logic              done_i,
  input  logic              wake_done_i,
  output logic              cclk_o,
  output logic              cclk_oe
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  cclk_state_e       state_q, state_d;
  logic [FSEL_W-1:0] fsel_q, fsel_d;
  logic              start, master_now;
  logic              cclk_bit, rise_tick, fall_tick, reached;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  cfg_prog_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk_osc),
    .rst_n (rst_n_int),
    .req_n (prog_req_n),
    .fall  (start)
  );

  assign master_now = MASTER_MASK[mode_sel];

  always_comb begin
    state_d = state_q;
    fsel_d  = fsel_q;
    if (start) begin
      fsel_d  = freq_sel;
      state_d = master_now ? ST_RUN : ST_IDLE;
    end else begin
      case (state_q)
        ST_RUN:  if (done_i && wake_done_i) state_d = ST_TAIL;
        ST_TAIL: if (reached && fall_tick)  state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_osc or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q <= ST_IDLE;
      fsel_q  <= '0;
    end else begin
      state_q <= state_d;
      fsel_q  <= fsel_d;
    end
  end

  cfg_clk_div #(.FSEL_W(FSEL_W)) div_i (
    .clk       (clk_osc),
    .rst_n     (rst_n_int),
    .clr       (start),
    .run       (state_q != ST_IDLE),
    .fsel      (fsel_q),
    .cclk_bit  (cclk_bit),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  cfg_tail_cnt #(.TAIL_CLKS(TAIL_CLKS)) tail_i (
    .clk     (clk_osc),
    .rst_n   (rst_n_int),
    .clr     (start || (state_q != ST_TAIL)),
    .inc     (rise_tick),
    .reached (reached)
  );

  assign cclk_oe = (state_q != ST_IDLE);
  assign cclk_o  = cclk_oe & cclk_bit;

  // R2
  master_start_chk: assert property (@(posedge clk_osc) disable iff (!rst_n_int)
    (start && master_now) |=> cclk_oe);
  // R3
  slave_start_chk: assert property (@(posedge clk_osc) disable iff (!rst_n_int)
    (start && !master_now) |=> !cclk_oe);
  // R5
  stop_phase_chk: assert property (@(posedge clk_osc) disable iff (!rst_n_int)
    $fell(cclk_oe) |-> ($past(cclk_o) || $past(start)));
endmodule

// File: tb/cfg_clk_ctrl_tb_top.sv
module cfg_clk_ctrl_tb_top;
  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 1;
  localparam int TAIL = 120;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       prog_req_n;
  logic [2:0] mode_sel;
  logic [1:0] freq_sel;
  logic       done_i, wake_done_i;
  logic       cclk_o, cclk_oe;

  int checks = 0;
  int fails  = 0;
  int jj     = 0;
  bit summed = 0;

  always #5 clk = ~clk;

  cfg_clk_ctrl dut_i (
    .clk_osc     (clk),
    .rst_n       (rst_n),
    .prog_req_n  (prog_req_n),
    .mode_sel    (mode_sel),
    .freq_sel    (freq_sel),
    .done_i      (done_i),
    .wake_done_i (wake_done_i),
    .cclk_o      (cclk_o),
    .cclk_oe     (cclk_oe)
  );

  function automatic bit is_master(input logic [2:0] m);
    return (m == 3'd6) || (m == 3'd7);
  endfunction

  function automatic int exp_clk(input int j, input int k);
    return (j >> k) & 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!summed) begin
      summed = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    end
  endtask

  // drive a start; returns at the first driven sample (j = 0)
  task automatic start_cfg(input logic [2:0] m, input int k, input bit from_idle);
    @(negedge clk);
    mode_sel   = m;
    freq_sel   = 2'(k);
    prog_req_n = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    if (from_idle) chk("R2 oe before latency", int'(cclk_oe), 0);
    @(negedge clk);
    prog_req_n = 1'b1;
    jj = 0;
  endtask

  task automatic pattern(input int k, input int n, input bit noise);
    for (int i = 0; i < n; i++) begin
      chk("R4 R10 oe", int'(cclk_oe), 1);
      chk("R4 R7 R6 clk", int'(cclk_o), exp_clk(jj, k));
      if (noise) begin
        freq_sel    = 2'($urandom);
        done_i      = 1'($urandom);
        wake_done_i = ~done_i & 1'($urandom);
      end
      @(negedge clk);
      jj++;
    end
    done_i      = 1'b0;
    wake_done_i = 1'b0;
  endtask

  task automatic tail_run();
    int rises = 0;
    int n     = 0;
    logic prev, cur;
    done_i      = 1'b1;
    wake_done_i = 1'b1;
    @(negedge clk);
    prev = cclk_o;
    while (n < 4000) begin
      @(negedge clk);
      n++;
      if (n == 20) begin
        done_i      = 1'b0;  // R8
        wake_done_i = 1'b0;
      end
      cur = cclk_o;
      if (cur && !prev) rises++;
      if (!cclk_oe) break;
      prev = cur;
    end
    done_i      = 1'b0;
    wake_done_i = 1'b0;
    chk("R5 R8 tail rises", rises, TAIL);
    chk("R5 last phase high", int'(prev), 1);
    chk("R5 clk low at release", int'(cclk_o), 0);
    repeat (10) @(negedge clk);
    chk("R5 stays released", int'(cclk_oe), 0);
  endtask

  task automatic slave_hold(input int n);
    for (int i = 0; i < n; i++) begin
      chk("R3 oe", int'(cclk_oe), 0);
      chk("R3 clk", int'(cclk_o), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int seed;
    bit active;
    seed        = $urandom(32'd2024);
    rst_n       = 1'b0;
    prog_req_n  = 1'b1;
    mode_sel    = '0;
    freq_sel    = '0;
    done_i      = 1'b0;
    wake_done_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", int'(cclk_oe), 0);
    chk("R1 clk in reset", int'(cclk_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 oe after reset", int'(cclk_oe), 0);

    // directed: fastest divide, clean inputs
    start_cfg(3'd7, 0, 1);
    pattern(0, 20, 0);
    tail_run();

    // slowest divide with frequency and single-indication noise
    start_cfg(3'd6, 3, 1);
    pattern(3, 64, 1);
    tail_run();

    // slave from idle
    start_cfg(3'd2, 1, 1);
    slave_hold(16);

    // restart while driving (R9)
    start_cfg(3'd7, 1, 1);
    pattern(1, 10, 0);
    start_cfg(3'd6, 2, 0);
    pattern(2, 24, 0);
    start_cfg(3'd3, 0, 0);
    slave_hold(8);

    // random picks
    active = 0;
    for (int it = 0; it < 14; it++) begin
      logic [2:0] m;
      int k;
      m = 3'($urandom);
      if (it % 3 == 0) m = 3'd6 | 3'($urandom & 1);
      k = int'($urandom % 4);
      start_cfg(m, k, !active);
      if (is_master(m)) begin
        pattern(k, 16 + int'($urandom % 24), 1'($urandom));
        if ($urandom % 2 == 0) begin
          tail_run();
          active = 0;
        end else begin
          active = 1;
        end
      end else begin
        slave_hold(8);
        active = 0;
      end
    end

    summary();
    $finish;
  end
endmodule